// File: doc/BRIEF.md
# Aliased General Register File

This block holds the eight 32-bit general registers of an integer core. Each register can be reached whole, through its low 16-bit word, or through its low byte. The first four registers also offer a second byte made of bits 15:8. One write port and two independent read ports each carry a register index and a 2-bit view code. A narrow write changes only the bits its view covers. A read returns the selected view zero-extended to 32 bits.

A separate checker screens the index register proposed for an address calculation. Register 4, the stack pointer, may serve as a base but never as an index, so the block raises a flag when it is offered in that role.

All pins are plain control and data signals. Reads are combinational and a write completes at the next rising clock edge. No port has a handshake, so the block applies no back-pressure: every request is served in the cycle it is presented.

Top module: `gpr_alias_file`

## Requirements
- R1: View code 2'b00 (full) writes all 32 bits of the register selected by `wr_idx` at the rising clock edge when `wr_en` is high. A full read returns all 32 bits.
- R2: View code 2'b01 (word) writes only bits 15:0 from `wr_data[15:0]` and leaves bits 31:16 unchanged. A word read returns bits 15:0 with bits 31:16 forced to zero.
- R3: View code 2'b10 (low byte) writes only bits 7:0 from `wr_data[7:0]` and keeps bits 31:8. It is legal for every register, and a read returns bits 7:0 zero-extended.
- R4: View code 2'b11 (high byte) is legal only for registers 0 to 3. It writes bits 15:8 from `wr_data[7:0]` and keeps all other bits, and a read returns bits 15:8 in result bits 7:0 zero-extended.
- R5: A high-byte request on registers 4 to 7 raises that port's error output (`wr_err`, `ra_err`, `rb_err`) in the same cycle. Such a write changes no register, and such a read returns zero.
- R6: Both read ports are combinational and independent. A read of the register being written in the same cycle returns the value from before the clock edge.
- R7: While the synchronous reset `rst` is high at a rising edge, all eight registers clear to zero, and any write in that cycle is discarded.
- R8: `agu_idx_bad` is high exactly when `agu_chk_en` is high and `agu_idx` equals 4 (the stack pointer). It is low for every other index and whenever `agu_chk_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_view | input | 2 | Write view code |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| wr_err | output | 1 | Illegal write view |
| ra_idx | input | 3 | Read port A register index |
| ra_view | input | 2 | Read port A view code |
| ra_data | output | 32 | Read port A data, zero-extended |
| ra_err | output | 1 | Illegal read view on port A |
| rb_idx | input | 3 | Read port B register index |
| rb_view | input | 2 | Read port B view code |
| rb_data | output | 32 | Read port B data, zero-extended |
| rb_err | output | 1 | Illegal read view on port B |
| agu_chk_en | input | 1 | An index register is being proposed |
| agu_idx | input | 3 | Proposed index register |
| agu_idx_bad | output | 1 | Proposed index register is not allowed |

## Verification
Every register is first loaded with a distinct 32-bit background and then written under each of the four views. It is then read back under all four views on both ports. This sweep separates a merge that spills into neighbouring bits from an extract that fails to zero-extend. It also exposes a high byte taken from the wrong lane. High-byte writes and reads on registers 4 to 7 check that an illegal view neither corrupts state nor leaks data. A same-cycle read and write of one register shows whether the read sees the old value. A sweep of all index and enable combinations on the address check finds any wrong forbidden index.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    VIEW_FULL = 2'b00,
    VIEW_WORD = 2'b01,
    VIEW_BLO  = 2'b10,
    VIEW_BHI  = 2'b11
  } view_e;
endpackage

// File: rtl/gpr_view_legal.sv
module gpr_view_legal #(
  parameter int IDX_W    = 3,
  parameter int HI_REGS  = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       view,
  output logic             illegal
);
  import gpr_pkg::*;
  always_comb begin
    illegal = (view_e'(view) == VIEW_BHI) && (int'(idx) >= HI_REGS);
  end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_data,
  input  logic [1:0]      view,
  output logic [XLEN-1:0] merged
);
  import gpr_pkg::*;
  always_comb begin
    merged = old_val;
    unique case (view_e'(view))
      VIEW_FULL: merged = new_data;
      VIEW_WORD: merged[15:0] = new_data[15:0];
      VIEW_BLO:  merged[7:0]  = new_data[7:0];
      VIEW_BHI:  merged[15:8] = new_data[7:0];
      default:   merged = old_val;
    endcase
  end
endmodule

// File: rtl/gpr_read_view.sv
module gpr_read_view #(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 3,
  parameter int HI_REGS = 4
) (
  input  logic [XLEN-1:0]  reg_val,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       view,
  output logic [XLEN-1:0]  rdata,
  output logic             err
);
  import gpr_pkg::*;
  logic bad;

  gpr_view_legal #(.IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_legal (
    .idx(idx), .view(view), .illegal(bad)
  );

  always_comb begin
    rdata = '0;
    err   = bad;
    if (!bad) begin
      unique case (view_e'(view))
        VIEW_FULL: rdata = reg_val;
        VIEW_WORD: rdata[15:0] = reg_val[15:0];
        VIEW_BLO:  rdata[7:0]  = reg_val[7:0];
        VIEW_BHI:  rdata[7:0]  = reg_val[15:8];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file #(
  parameter int XLEN      = 32,
  parameter int NUM_REGS  = 8,
  parameter int HI_REGS   = 4,
  parameter int NO_INDEX  = 4,
  parameter int IDX_W     = $clog2(NUM_REGS),
  parameter int NUM_RD    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_view,
  input  logic [XLEN-1:0]  wr_data,
  output logic             wr_err,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [1:0]       ra_view,
  output logic [XLEN-1:0]  ra_data,
  output logic             ra_err,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [1:0]       rb_view,
  output logic [XLEN-1:0]  rb_data,
  output logic             rb_err,
  input  logic             agu_chk_en,
  input  logic [IDX_W-1:0] agu_idx,
  output logic             agu_idx_bad
);
  logic [XLEN-1:0]  regs   [NUM_REGS];
  logic [XLEN-1:0]  merged;
  logic             wr_bad;
  logic [IDX_W-1:0] rd_idx  [NUM_RD];
  logic [1:0]       rd_view [NUM_RD];
  logic [XLEN-1:0]  rd_data [NUM_RD];
  logic             rd_err  [NUM_RD];

  gpr_view_legal #(.IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_wr_legal (
    .idx(wr_idx), .view(wr_view), .illegal(wr_bad)
  );

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .old_val(regs[wr_idx]), .new_data(wr_data), .view(wr_view), .merged(merged)
  );

  assign wr_err = wr_bad;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && !wr_bad && (int'(wr_idx) == g)) begin
        regs[g] <= merged;
      end
    end
  end

  assign rd_idx[0]  = ra_idx;
  assign rd_view[0] = ra_view;
  assign rd_idx[1]  = rb_idx;
  assign rd_view[1] = rb_view;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_view #(.XLEN(XLEN), .IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_rd (
      .reg_val(regs[rd_idx[p]]), .idx(rd_idx[p]), .view(rd_view[p]),
      .rdata(rd_data[p]), .err(rd_err[p])
    );
  end

  assign ra_data = rd_data[0];
  assign ra_err  = rd_err[0];
  assign rb_data = rd_data[1];
  assign rb_err  = rd_err[1];

  assign agu_idx_bad = agu_chk_en && (int'(agu_idx) == NO_INDEX);
endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_view,
  input logic [XLEN-1:0]  wr_data,
  input logic             wr_err,
  input logic [IDX_W-1:0] ra_idx,
  input logic [1:0]       ra_view,
  input logic [XLEN-1:0]  ra_data,
  input logic             ra_err,
  input logic [XLEN-1:0]  rb_data,
  input logic             rb_err,
  input logic             agu_chk_en,
  input logic             agu_idx_bad
);
  // R7
  reset_clears_chk: assert property (@(posedge clk) rst |=> (ra_data == '0 && rb_data == '0));

  // R1
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view == 2'b00 && ra_idx == wr_idx && ra_view == 2'b00)
    |=> (!$stable(ra_idx) || !$stable(ra_view) || ra_data == $past(wr_data)));

  // R2
  word_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view == 2'b01 && ra_idx == wr_idx && ra_view == 2'b00)
    |=> (!$stable(ra_idx) || !$stable(ra_view) || ra_data[31:16] == $past(ra_data[31:16])));

  // R3
  blo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view == 2'b10 && ra_idx == wr_idx && ra_view == 2'b00)
    |=> (!$stable(ra_idx) || !$stable(ra_view) || ra_data[31:8] == $past(ra_data[31:8])));

  // R5
  bad_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_err && ra_idx == wr_idx && ra_view == 2'b00)
    |=> (!$stable(ra_idx) || !$stable(ra_view) || $stable(ra_data)));

  // R5
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_err |-> ra_data == '0) and (rb_err |-> rb_data == '0));

  // R5
  err_only_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> wr_view == 2'b11);

  // R4
  hi_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_view == 2'b11) |-> ra_data[31:8] == '0);

  // R8
  agu_gate_chk: assert property (@(posedge clk) disable iff (rst)
    agu_idx_bad |-> agu_chk_en);
endmodule

bind gpr_alias_file gpr_alias_file_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
  .wr_data(wr_data), .wr_err(wr_err), .ra_idx(ra_idx), .ra_view(ra_view),
  .ra_data(ra_data), .ra_err(ra_err), .rb_data(rb_data), .rb_err(rb_err),
  .agu_chk_en(agu_chk_en), .agu_idx_bad(agu_idx_bad)
);

// File: tb/tb_gpr_alias_file.sv
`timescale 1ns/1ps
module tb_gpr_alias_file;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_view;
  logic [31:0] wr_data;
  logic        wr_err;
  logic [2:0]  ra_idx, rb_idx;
  logic [1:0]  ra_view, rb_view;
  logic [31:0] ra_data, rb_data;
  logic        ra_err, rb_err;
  logic        agu_chk_en;
  logic [2:0]  agu_idx;
  logic        agu_idx_bad;

  int tests = 0;
  int fails = 0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  gpr_alias_file dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
    .wr_data(wr_data), .wr_err(wr_err), .ra_idx(ra_idx), .ra_view(ra_view),
    .ra_data(ra_data), .ra_err(ra_err), .rb_idx(rb_idx), .rb_view(rb_view),
    .rb_data(rb_data), .rb_err(rb_err), .agu_chk_en(agu_chk_en),
    .agu_idx(agu_idx), .agu_idx_bad(agu_idx_bad)
  );

  function automatic logic illegal(int idx, int v);
    return (v == 3) && (idx >= 4);
  endfunction

  function automatic logic [31:0] view_val(logic [31:0] r, int idx, int v);
    if (illegal(idx, v)) return 32'h0;
    case (v)
      0: return r;
      1: return r % 32'h10000;
      2: return r % 32'h100;
      default: return (r / 32'h100) % 32'h100;
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] r, logic [31:0] d, int v);
    logic [31:0] m;
    logic [31:0] s;
    case (v)
      0: begin m = 32'hFFFF_FFFF; s = d; end
      1: begin m = 32'h0000_FFFF; s = d; end
      2: begin m = 32'h0000_00FF; s = d; end
      default: begin m = 32'h0000_FF00; s = d * 32'h100; end
    endcase
    return (r & ~m) | (s & m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(int idx, int v, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_view = 2'(v); wr_data = d;
    #1;
    check("R5 wr_err", {31'b0, wr_err}, {31'b0, illegal(idx, v)});
    @(posedge clk);
    if (!illegal(idx, v)) model[idx] = merge(model[idx], d, v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_all(int idx, string req);
    for (int v = 0; v < 4; v++) begin
      ra_idx = 3'(idx); ra_view = 2'(v);
      rb_idx = 3'(7 - idx); rb_view = 2'(v);
      #1;
      check(req, ra_data, view_val(model[idx], idx, v));
      check(req, rb_data, view_val(model[7 - idx], 7 - idx, v));
      check("R5 rd_err", {30'b0, ra_err, rb_err},
            {30'b0, illegal(idx, v), illegal(7 - idx, v)});
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = 0; wr_view = 0; wr_data = 0;
    ra_idx = 0; ra_view = 0; rb_idx = 0; rb_view = 0;
    agu_chk_en = 0; agu_idx = 0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    // R7: write during reset is discarded
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd2; wr_data = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    wr_en = 1'b0; rst = 1'b0;
    for (int i = 0; i < 8; i++) read_all(i, "R7 reset");

    // R1 R2 R3 R4: every register, every view, over a background
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 4; v++) begin
        do_write(i, 0, 32'h8765_4321 ^ (32'(i) * 32'h1111_1111));
        do_write(i, v, 32'h1234_5678 ^ (32'(v) * 32'h0101_0000) ^ 32'(i * 9));
        read_all(i, v == 0 ? "R1" : v == 1 ? "R2" : v == 2 ? "R3" : "R4 R5");
      end
    end

    // R6: same-cycle read returns old value, new value after edge
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd3; wr_view = 2'd0; wr_data = 32'hCAFE_F00D;
    ra_idx = 3'd3; ra_view = 2'd0; rb_idx = 3'd3; rb_view = 2'd3;
    #1;
    check("R6 old A", ra_data, model[3]);
    check("R6 old B", rb_data, view_val(model[3], 3, 3));
    @(posedge clk);
    model[3] = 32'hCAFE_F00D;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R6 new A", ra_data, 32'hCAFE_F00D);
    check("R6 new B", rb_data, 32'h0000_00F0);

    // R7: reset after traffic clears all
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    for (int i = 0; i < 8; i++) read_all(i, "R7 re-reset");

    // R8: address index check sweep
    for (int e = 0; e < 2; e++) begin
      for (int k = 0; k < 8; k++) begin
        agu_chk_en = e[0]; agu_idx = 3'(k);
        #1;
        check("R8", {31'b0, agu_idx_bad}, {31'b0, (e == 1) && (k == 4)});
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule